// File: doc/BRIEF.md
# Sequential Early-Terminating Integer Divider

This block divides one 32-bit integer by another and produces a quotient and a remainder. It works one quotient bit per clock with the restoring shift-and-subtract method. In the cycle it accepts an operation, a find-highest-set-bit circuit measures how many significant bits the dividend magnitude has. The dividend is then shifted left so that its top set bit sits in the most significant position. Only the significant bits are iterated, so a small dividend finishes in a few clocks.

A caller presents the operands and a signed/unsigned select, and pulses `start` while the block is idle. `busy` stays high for the whole operation. `done` pulses for one clock when the result registers are loaded. The results then hold until the next operation completes. A zero divisor sets a flag and returns a fixed pattern without iterating.

Top module: `int_divider`

## Requirements
- R1: In unsigned mode (`signed_mode`=0), `quotient` equals floor(dividend/divisor) and `remainder` equals dividend minus quotient×divisor, for any nonzero divisor.
- R2: In signed mode (`signed_mode`=1), operands are two's complement. The quotient is truncated toward zero and is negated when the operand signs differ. The remainder takes the sign of the dividend, and its magnitude is less than the magnitude of the divisor.
- R3: Let N be the bit count of the dividend magnitude up to and including its highest set bit (N=0 for a zero dividend). `done` is high in the (N+1)th clock after the edge that accepts `start`. A zero dividend gives quotient 0 and remainder 0.
- R4: A zero divisor raises `div_zero`, gives a quotient of all ones and a remainder equal to the dividend unchanged, and uses N=0 for the timing of R3. `div_zero` is 0 after any division with a nonzero divisor.
- R5: `done` is high for exactly one clock, and `busy` is low in that clock.
- R6: `busy` rises in the clock after an accepted `start`. A `start` while `busy` is high is ignored: the running operation keeps its operands, its result and its latency.
- R7: `quotient`, `remainder` and `div_zero` change only when an operation completes. Between completions they hold their values, whatever the operand inputs do.
- R8: In signed mode, 0x80000000 divided by 0xFFFFFFFF (−1) gives quotient 0x80000000 and remainder 0.
- R9: After reset, `busy`, `done` and `div_zero` are 0, and `quotient` and `remainder` are 0.
- R10: A `start` raised in the clock where `done` is high is accepted, and its own operation then meets R1 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division when idle |
| signed_mode | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | 32 | Numerator, sampled on the accepting edge |
| divisor | input | 32 | Denominator, sampled on the accepting edge |
| quotient | output | 32 | Result quotient, held until next completion |
| remainder | output | 32 | Result remainder, held until next completion |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| div_zero | output | 1 | Last completed division had a zero divisor |

## Verification
Two events can fall in the same clock: the completion of one division and the acceptance of the next. Both can also coincide with a fresh `start` arriving mid-iteration. The bench raises `start` with new operands in the very clock where `done` is high. It then checks that the first result was loaded, and that the second operation runs with its own operands and its own latency of N+1. In a separate scenario it pulses `start` with other operands during the iteration, and judges by comparing the result and the cycle count with the values for the original operands only.

// File: rtl/div_pkg.sv
package div_pkg;

  localparam int DIV_W = 32;
  localparam int CNT_W = $clog2(DIV_W + 1);

  typedef logic [DIV_W-1:0] word_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    word_t rem;
    logic  qbit;
  } step_t;

  // absolute value when the operand is treated as signed
  function automatic word_t magnitude(word_t v, logic sgn);
    return (sgn && v[DIV_W-1]) ? word_t'(-v) : v;
  endfunction

  // position of the highest set bit plus one; zero for a zero word
  function automatic cnt_t sig_bits(word_t v);
    cnt_t n;
    n = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (v[i]) n = cnt_t'(i + 1);
    end
    return n;
  endfunction

  // one restoring step: shift in a bit, subtract when it fits
  function automatic step_t restore_step(word_t rem, logic inbit, word_t dsr);
    logic [DIV_W+1:0] trial;
    step_t s;
    trial  = {1'b0, rem, inbit} - {2'b00, dsr};
    s.qbit = ~trial[DIV_W+1];
    s.rem  = s.qbit ? trial[DIV_W-1:0] : {rem[DIV_W-2:0], inbit};
    return s;
  endfunction

endpackage

// File: rtl/div_prep.sv
module div_prep
  import div_pkg::*;
(
  input  word_t dividend,
  input  word_t divisor,
  input  logic  signed_mode,
  output word_t dvd_aligned,
  output word_t dsr_mag,
  output cnt_t  n_iter,
  output logic  neg_quo,
  output logic  neg_rem,
  output logic  zero_dsr
);

  word_t mag_a;
  cnt_t  nbits;

  always_comb begin
    mag_a       = magnitude(dividend, signed_mode);
    dsr_mag     = magnitude(divisor, signed_mode);
    nbits       = sig_bits(mag_a);
    zero_dsr    = (divisor == '0);
    // early-in: place the top set bit at the MSB
    dvd_aligned = mag_a << (DIV_W - int'(nbits));
    n_iter      = zero_dsr ? '0 : nbits;
    neg_quo     = signed_mode && (dividend[DIV_W-1] ^ divisor[DIV_W-1]) && !zero_dsr;
    neg_rem     = signed_mode && dividend[DIV_W-1] && !zero_dsr;
  end

  always_comb begin
    assert (nbits <= cnt_t'(DIV_W)) else $error("p_bits_in_range_r3");
  end

endmodule

// File: rtl/div_step.sv
module div_step
  import div_pkg::*;
(
  input  word_t rem_in,
  input  logic  dvd_bit,
  input  word_t dsr,
  output word_t rem_out,
  output logic  qbit
);

  step_t s;

  always_comb begin
    s       = restore_step(rem_in, dvd_bit, dsr);
    rem_out = s.rem;
    qbit    = s.qbit;
  end

  // a nonzero divisor always leaves a partial remainder below it (R1)
  always_comb begin
    if (dsr != '0) assert (rem_out < dsr) else $error("p_rem_below_divisor_r1");
  end

endmodule

// File: rtl/int_divider.sv
module int_divider
  import div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              signed_mode,
  input  logic [DIV_W-1:0]  dividend,
  input  logic [DIV_W-1:0]  divisor,
  output logic [DIV_W-1:0]  quotient,
  output logic [DIV_W-1:0]  remainder,
  output logic              busy,
  output logic              done,
  output logic              div_zero
);

  // setup results
  word_t pre_dvd, pre_dsr;
  cnt_t  pre_n;
  logic  pre_negq, pre_negr, pre_dz;

  div_prep u_prep (
    .dividend    (dividend),
    .divisor     (divisor),
    .signed_mode (signed_mode),
    .dvd_aligned (pre_dvd),
    .dsr_mag     (pre_dsr),
    .n_iter      (pre_n),
    .neg_quo     (pre_negq),
    .neg_rem     (pre_negr),
    .zero_dsr    (pre_dz)
  );

  // iteration state
  word_t dvd_q, dsr_q, rem_q, quo_q;
  cnt_t  cnt_q;
  logic  busy_q, done_q, negq_q, negr_q, dz_q;
  word_t quot_q, remd_q;
  logic  dzout_q;

  word_t step_rem;
  logic  step_bit;

  div_step u_step (
    .rem_in  (rem_q),
    .dvd_bit (dvd_q[DIV_W-1]),
    .dsr     (dsr_q),
    .rem_out (step_rem),
    .qbit    (step_bit)
  );

  // named internal events
  logic accept_w, iterate_w, finish_w;
  assign accept_w  = start && !busy_q;
  assign iterate_w = busy_q && (cnt_q != '0);
  assign finish_w  = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q   <= '0;
      dsr_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      dz_q    <= 1'b0;
      quot_q  <= '0;
      remd_q  <= '0;
      dzout_q <= 1'b0;
    end else begin
      done_q <= finish_w;
      if (accept_w) begin
        busy_q <= 1'b1;
        dvd_q  <= pre_dvd;
        dsr_q  <= pre_dsr;
        quo_q  <= '0;
        rem_q  <= pre_dz ? dividend : '0;
        cnt_q  <= pre_n;
        negq_q <= pre_negq;
        negr_q <= pre_negr;
        dz_q   <= pre_dz;
      end else if (iterate_w) begin
        dvd_q  <= dvd_q << 1;
        rem_q  <= step_rem;
        quo_q  <= {quo_q[DIV_W-2:0], step_bit};
        cnt_q  <= cnt_q - 1'b1;
      end else if (finish_w) begin
        busy_q  <= 1'b0;
        quot_q  <= dz_q ? '1 : (negq_q ? word_t'(-quo_q) : quo_q);
        remd_q  <= negr_q ? word_t'(-rem_q) : rem_q;
        dzout_q <= dz_q;
      end
    end
  end

  assign quotient  = quot_q;
  assign remainder = remd_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign div_zero  = dzout_q;

  // assertions
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> busy);

  p_restart_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iterate_w |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !finish_w |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

  p_zero_div_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (quotient == '1));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cnt_t'(DIV_W));

endmodule

// File: tb/tb_int_divider.sv
module tb_int_divider;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic [31:0] quotient, remainder;
  logic        busy, done, div_zero;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  int_divider dut (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .dividend(dividend), .divisor(divisor), .quotient(quotient),
    .remainder(remainder), .busy(busy), .done(done), .div_zero(div_zero)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected results computed in 64-bit arithmetic
  function automatic logic [31:0] e_quo(logic [31:0] a, logic [31:0] b, bit s);
    longint x, y;
    if (b == 0) return 32'hFFFF_FFFF;
    x = s ? longint'($signed(a)) : longint'({32'b0, a});
    y = s ? longint'($signed(b)) : longint'({32'b0, b});
    return 32'(x / y);
  endfunction

  function automatic logic [31:0] e_rem(logic [31:0] a, logic [31:0] b, bit s);
    longint x, y;
    if (b == 0) return a;
    x = s ? longint'($signed(a)) : longint'({32'b0, a});
    y = s ? longint'($signed(b)) : longint'({32'b0, b});
    return 32'(x % y);
  endfunction

  function automatic int e_lat(logic [31:0] a, logic [31:0] b, bit s);
    longint m;
    if (b == 0) return 1;
    m = (s && a[31]) ? -longint'($signed(a)) : longint'({32'b0, a});
    return $clog2(m + 1) + 1;
  endfunction

  task automatic launch(input logic [31:0] a, input logic [31:0] b, input bit s);
    dividend = a; divisor = b; signed_mode = s; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // counts clocks from the accepting edge; returns at the negedge where done is high
  task automatic collect(input logic [31:0] a, input logic [31:0] b, input bit s,
                         input string tag, input int inject_at);
    int cyc = 0;
    while (cyc < 40) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (cyc == inject_at) begin
        dividend = 32'h0000_0007; divisor = 32'h0000_0002; signed_mode = ~s; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) break;
    end
    start = 1'b0;
    chk(cyc == e_lat(a, b, s), {tag, " R3 latency"}, cyc, e_lat(a, b, s));
    chk(quotient == e_quo(a, b, s), {tag, s ? " R2 quotient" : " R1 quotient"}, quotient, e_quo(a, b, s));
    chk(remainder == e_rem(a, b, s), {tag, s ? " R2 remainder" : " R1 remainder"}, remainder, e_rem(a, b, s));
    chk(div_zero == (b == 0), {tag, " R4 div_zero"}, div_zero, b == 0);
    chk(!busy, {tag, " R5 busy low at done"}, busy, 0);
  endtask

  task automatic check_drop(input string tag);
    @(negedge clk);
    chk(!done, {tag, " R5 done one clock"}, done, 0);
  endtask

  task automatic run_div(input logic [31:0] a, input logic [31:0] b, input bit s, input string tag);
    @(negedge clk);
    launch(a, b, s);
    chk(busy, {tag, " R6 busy after accept"}, busy, 1);
    collect(a, b, s, tag, -1);
    check_drop(tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !div_zero, "R9 flags", {busy, done, div_zero}, 0);
    chk(quotient == 0 && remainder == 0, "R9 results", quotient | remainder, 0);
  endtask

  task automatic t_unsigned();
    run_div(32'd100, 32'd7, 0, "u1");
    run_div(32'hFFFF_FFFF, 32'd3, 0, "u2");
    run_div(32'd5, 32'd9, 0, "u3");
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 0, "u4");
  endtask

  task automatic t_signed();
    run_div(-32'sd100, 32'sd7, 1, "s1");
    run_div(32'sd100, -32'sd7, 1, "s2");
    run_div(-32'sd100, -32'sd7, 1, "s3");
    run_div(32'sd7, -32'sd100, 1, "s4");
  endtask

  task automatic t_boundary();
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1, "R8 minint/-1");
    chk(quotient == 32'h8000_0000 && remainder == 0, "R8 value", quotient, 32'h8000_0000);
    run_div(32'h1234_5678, 32'd1, 0, "div1 u");
    run_div(32'hF234_5678, 32'd1, 1, "div1 s");
    run_div(32'hDEAD_BEEF, 32'd0, 0, "R4 zero u");
    run_div(32'h8000_0001, 32'd0, 1, "R4 zero s");
    run_div(32'd0, 32'd5, 0, "R3 zero dividend");
    run_div(32'd0, 32'd0, 1, "R4 zero/zero");
  endtask

  task automatic t_small();
    for (int i = 1; i < 9; i++) run_div(32'(i), 32'd2, 0, "small u");
    run_div(32'hFFFF_FFFF, 32'd1, 1, "small -1/1");
    run_div(32'hFFFF_FFFE, 32'd3, 1, "small -2/3");
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 3 == 1) a = a >> (a[4:0]);
      if (i % 4 == 2) b = b >> (b[4:0] + 5'd8);
      run_div(a, b, bit'(i % 2), "rand");
    end
  endtask

  task automatic t_ignore_start();
    @(negedge clk);
    launch(32'hFFFF_0000, 32'd3, 0);
    collect(32'hFFFF_0000, 32'd3, 0, "R6 ignore start", 4);
    check_drop("R6 ignore start");
  endtask

  task automatic t_hold();
    logic [31:0] q, r;
    logic dz;
    run_div(32'd1000, 32'd0, 0, "R7 pre");
    q = quotient; r = remainder; dz = div_zero;
    dividend = 32'd9; divisor = 32'd4; signed_mode = 1;
    repeat (6) @(negedge clk);
    chk(quotient == q && remainder == r && div_zero == dz, "R7 hold", quotient, q);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    launch(32'd1000, 32'd7, 0);
    collect(32'd1000, 32'd7, 0, "R10 first", -1);
    launch(-32'sd50, 32'sd6, 1);
    chk(busy, "R10 accepted in done clock", busy, 1);
    collect(-32'sd50, 32'sd6, 1, "R10 second", -1);
    check_drop("R10 second");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unsigned();
    t_signed();
    t_boundary();
    t_small();
    t_ignore_start();
    t_hold();
    t_back_to_back();
    t_random();
    finish_run();
  end

endmodule